// File: doc/BRIEF.md
# Single-Step Trap Sequencer

This block is the trap-flag and resume-flag part of a debug unit in a simple in-order CPU. It holds the live 32-bit flags word. A flags write port loads that word; flag-restore and return-from-exception instructions drive this port. The block watches an instruction-retire strobe and decides when a single-step debug exception is due. When one is due, it raises a request that carries vector 1 and pulses the single-step bit of a debug-status set mask.

A newly written trap flag does not take effect at once. The instruction that wrote it retires without a trap. The next retirement only arms stepping. From then on, every retirement raises the request. A set resume flag cancels one such trap, and the hardware clears that flag at the next retirement. The exception-entry acknowledge does two things: it retires the request, and it clears the trap and resume flags in the live word. Before the clear, the pre-exception word is visible on the flags output, so the entry logic can save it.

Top module: `sstep_trap_seq`

## Requirements
- R1: After reset, the flags output is 0, the request is low and the status set mask is 0. The vector output always reads 1.
- R2: When the write strobe is high at a clock edge, the flags output shows the written word from the next cycle. The trap-flag output follows bit 8 and the resume-flag output follows bit 16.
- R3: When a write changes bit 8 from 0 to 1, no request follows the retirement of the writing instruction (a retire in the same cycle as the write). No request follows the next retirement either; that retirement only arms stepping.
- R4: Once armed, with the trap flag set and the resume flag clear, each retirement raises the request in the following cycle. Idle cycles in between make no difference.
- R5: The status set mask equals 0x4000 (bit 14) for exactly one cycle: the first cycle of each request. At all other times it is 0.
- R6: The request stays high until an acknowledge. While it is pending, retirements are ignored: there is no second pulse, and the flags do not change.
- R7: The acknowledge takes effect one cycle later. From that cycle, the request is low and bits 8 and 16 of the flags are cleared, with all other bits kept. In the acknowledge cycle itself, the flags output still shows the pre-exception word.
- R8: While the resume flag is set, a retirement that would trap raises no request, and the resume flag reads 0 from the next cycle.
- R9: With the trap flag clear, retirements never raise the request.
- R10: A return-from-exception write that restores bit 8 (and possibly bit 16) after an acknowledge has the same one-retirement delay as R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retire_i | input | 1 | One instruction retired this cycle |
| flags_wr_i | input | 1 | Flags write strobe |
| flags_wdata_i | input | 32 | Flags word to write |
| exc_ack_i | input | 1 | Exception entry acknowledge |
| dbg_req_o | output | 1 | Debug exception request, held until acknowledge |
| dbg_vec_o | output | 8 | Exception vector (1) |
| stat_set_o | output | 32 | Debug status set mask, single-step bit pulse |
| flags_o | output | 32 | Live flags word |
| tf_o | output | 1 | Live trap flag |
| rf_o | output | 1 | Live resume flag |

## Verification
Every result is registered once. The flags, the request and the status pulse all change in the cycle after the edge that samples the retire, write or acknowledge. The bench drives inputs on the falling edge and samples one falling edge later, so it reads the value after exactly one register stage. Two values are read in the same cycle as the stimulus instead: the pre-exception flags word (R7), and the status pulse's one-cycle width, which is checked on the sample that follows the request's rise (R5).

// File: rtl/sstep_pkg.sv
package sstep_pkg;
  localparam int FLAG_W = 32;
  localparam int TF_POS = 8;
  localparam int RF_POS = 16;
  localparam int BS_POS = 14;
  localparam int VEC_W  = 8;
  localparam logic [VEC_W-1:0] STEP_VEC = 8'd1;

  function automatic logic tf_of(input logic [FLAG_W-1:0] w);
    return w[TF_POS];
  endfunction

  function automatic logic rf_of(input logic [FLAG_W-1:0] w);
    return w[RF_POS];
  endfunction

  function automatic logic [FLAG_W-1:0] drop_step(input logic [FLAG_W-1:0] w);
    logic [FLAG_W-1:0] r;
    r = w;
    r[TF_POS] = 1'b0;
    r[RF_POS] = 1'b0;
    return r;
  endfunction

  function automatic logic [FLAG_W-1:0] drop_resume(input logic [FLAG_W-1:0] w);
    logic [FLAG_W-1:0] r;
    r = w;
    r[RF_POS] = 1'b0;
    return r;
  endfunction

  function automatic logic [FLAG_W-1:0] bs_mask();
    logic [FLAG_W-1:0] r;
    r = '0;
    r[BS_POS] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/sstep_flags.sv
module sstep_flags
  import sstep_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [FLAG_W-1:0] wdata,
  input  logic              ack,
  input  logic              ret_ok,
  output logic [FLAG_W-1:0] flags
);
  always_ff @(posedge clk) begin
    if (!rst_n)                    flags <= '0;
    else if (ack)                  flags <= drop_step(flags);
    else if (wr)                   flags <= wdata;
    else if (ret_ok && rf_of(flags)) flags <= drop_resume(flags);
  end

  p_ack_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !tf_of(flags) && !rf_of(flags));

  p_rf_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ret_ok && rf_of(flags) && !wr && !ack |=> !rf_of(flags));
endmodule

// File: rtl/sstep_arm.sv
module sstep_arm
  import sstep_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tf,
  input  logic rf,
  input  logic wr,
  input  logic wr_tf,
  input  logic ack,
  input  logic ret_ok,
  output logic armed,
  output logic trap_evt
);
  logic tf_rise_wr;
  assign tf_rise_wr = wr && wr_tf && !tf;

  always_ff @(posedge clk) begin
    if (!rst_n)                     armed <= 1'b0;
    else if (ack)                   armed <= 1'b0;
    else if (tf_rise_wr || (wr && !wr_tf)) armed <= 1'b0;
    else if (ret_ok && tf)          armed <= 1'b1;
  end

  assign trap_evt = ret_ok && tf && armed && !rf && !ack && !tf_rise_wr;

  p_rise_unarmed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tf_rise_wr && !ack |=> !armed);
endmodule

// File: rtl/sstep_req.sv
module sstep_req (
  input  logic clk,
  input  logic rst_n,
  input  logic trap_evt,
  input  logic ack,
  output logic req,
  output logic bs_pulse
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req      <= 1'b0;
      bs_pulse <= 1'b0;
    end else begin
      bs_pulse <= trap_evt && !req;
      if (ack)           req <= 1'b0;
      else if (trap_evt) req <= 1'b1;
    end
  end

  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req && !ack |=> req);

  p_bs_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bs_pulse |=> !bs_pulse);
endmodule

// File: rtl/sstep_trap_seq.sv
module sstep_trap_seq
  import sstep_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              retire_i,
  input  logic              flags_wr_i,
  input  logic [31:0]       flags_wdata_i,
  input  logic              exc_ack_i,
  output logic              dbg_req_o,
  output logic [7:0]        dbg_vec_o,
  output logic [31:0]       stat_set_o,
  output logic [31:0]       flags_o,
  output logic              tf_o,
  output logic              rf_o
);
  logic [FLAG_W-1:0] flags;
  logic ret_ok, armed, trap_evt, req, bs_pulse;

  assign ret_ok = retire_i && !req && !exc_ack_i;

  sstep_flags u_flags (
    .clk(clk), .rst_n(rst_n), .wr(flags_wr_i), .wdata(flags_wdata_i),
    .ack(exc_ack_i), .ret_ok(ret_ok), .flags(flags)
  );

  sstep_arm u_arm (
    .clk(clk), .rst_n(rst_n), .tf(tf_of(flags)), .rf(rf_of(flags)),
    .wr(flags_wr_i), .wr_tf(tf_of(flags_wdata_i)), .ack(exc_ack_i),
    .ret_ok(ret_ok), .armed(armed), .trap_evt(trap_evt)
  );

  sstep_req u_req (
    .clk(clk), .rst_n(rst_n), .trap_evt(trap_evt), .ack(exc_ack_i),
    .req(req), .bs_pulse(bs_pulse)
  );

  assign dbg_req_o  = req;
  assign dbg_vec_o  = STEP_VEC;
  assign stat_set_o = bs_pulse ? bs_mask() : '0;
  assign flags_o    = flags;
  assign tf_o       = tf_of(flags);
  assign rf_o       = rf_of(flags);

  p_bs_on_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dbg_req_o) |-> stat_set_o == 32'h4000);

  p_no_req_tf_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tf_o && !dbg_req_o |=> !dbg_req_o);
endmodule

// File: tb/sstep_trap_seq_bench.sv
module sstep_trap_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic retire_i = 1'b0, flags_wr_i = 1'b0, exc_ack_i = 1'b0;
  logic [31:0] flags_wdata_i = '0;
  logic dbg_req_o, tf_o, rf_o;
  logic [7:0] dbg_vec_o;
  logic [31:0] stat_set_o, flags_o;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sstep_trap_seq u_sstep_trap_seq (
    .clk(clk), .rst_n(rst_n), .retire_i(retire_i), .flags_wr_i(flags_wr_i),
    .flags_wdata_i(flags_wdata_i), .exc_ack_i(exc_ack_i), .dbg_req_o(dbg_req_o),
    .dbg_vec_o(dbg_vec_o), .stat_set_o(stat_set_o), .flags_o(flags_o),
    .tf_o(tf_o), .rf_o(rf_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one cycle from a falling edge, return at the next falling edge
  task automatic tick(input logic r, input logic w, input logic [31:0] d, input logic a);
    retire_i = r; flags_wr_i = w; flags_wdata_i = d; exc_ack_i = a;
    @(negedge clk);
    retire_i = 0; flags_wr_i = 0; flags_wdata_i = '0; exc_ack_i = 0;
  endtask

  task automatic t_reset();
    chk("R1 flags", flags_o, 0);
    chk("R1 req", {31'd0, dbg_req_o}, 0);
    chk("R1 stat", stat_set_o, 0);
    chk("R1 vec", {24'd0, dbg_vec_o}, 1);
  endtask

  task automatic t_write();
    tick(0, 1, 32'h0001_0100, 0);
    chk("R2 flags", flags_o, 32'h0001_0100);
    chk("R2 tf", {31'd0, tf_o}, 1);
    chk("R2 rf", {31'd0, rf_o}, 1);
    tick(0, 1, 32'h0000_0042, 0);
    chk("R2 flags clear", flags_o, 32'h42);
    tick(1, 0, 0, 0);
    tick(1, 0, 0, 0);
    chk("R9 no req tf off", {31'd0, dbg_req_o}, 0);
  endtask

  task automatic t_step();
    tick(1, 1, 32'h0000_0301, 0);   // writer retires
    chk("R3 writer", {31'd0, dbg_req_o}, 0);
    tick(1, 0, 0, 0);               // arming retire
    chk("R3 arming", {31'd0, dbg_req_o}, 0);
    tick(0, 0, 0, 0);
    tick(0, 0, 0, 0);
    tick(1, 0, 0, 0);
    chk("R4 trap", {31'd0, dbg_req_o}, 1);
    chk("R4 vec", {24'd0, dbg_vec_o}, 1);
    chk("R5 bs", stat_set_o, 32'h4000);
    tick(1, 0, 0, 0);               // ignored while pending
    chk("R5 one cycle", stat_set_o, 0);
    chk("R6 hold", {31'd0, dbg_req_o}, 1);
    chk("R6 flags kept", flags_o, 32'h301);
    chk("R7 pre-exception", flags_o, 32'h301);
    tick(0, 0, 0, 1);
    chk("R7 req low", {31'd0, dbg_req_o}, 0);
    chk("R7 flags", flags_o, 32'h201);
    tick(1, 0, 0, 0);
    chk("R9 after ack", {31'd0, dbg_req_o}, 0);
  endtask

  task automatic t_restore();
    tick(1, 1, 32'h0001_0300, 0);   // return restores TF and RF
    chk("R10 writer", {31'd0, dbg_req_o}, 0);
    chk("R10 rf set", {31'd0, rf_o}, 1);
    tick(1, 0, 0, 0);
    chk("R10 first after return", {31'd0, dbg_req_o}, 0);
    chk("R8 rf cleared", {31'd0, rf_o}, 0);
    tick(1, 0, 0, 0);
    chk("R10 trap", {31'd0, dbg_req_o}, 1);
    tick(0, 0, 0, 1);
    chk("R7 cleared", flags_o, 32'h200);
  endtask

  task automatic t_resume();
    tick(1, 1, 32'h100, 0);
    tick(1, 0, 0, 0);               // armed now
    tick(0, 1, 32'h0001_0100, 0);   // set RF, TF stays
    tick(1, 0, 0, 0);
    chk("R8 suppressed", {31'd0, dbg_req_o}, 0);
    chk("R8 rf low", {31'd0, rf_o}, 0);
    tick(1, 0, 0, 0);
    chk("R4 trap after rf", {31'd0, dbg_req_o}, 1);
    tick(0, 0, 0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write();
    t_step();
    t_restore();
    t_resume();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule